// File: doc/BRIEF.md
# Power-of-Two Windowed Slave Array Multiplexer

This block joins one memory-mapped master port to an array of identical slave ports. Every slave in the array answers to the same number of word addresses. Each slave is given an address window whose size is that word count rounded up to the next power of two. A five-word slave therefore gets an eight-word window, and a 768-word slave gets a 1024-word window. Slave `i` starts at word address `i` times the window. The array covers `NOF_INST` times the window in words, which is four times that in bytes, since every word is 32 bits wide.

Because every window is a power of two, no adder or comparator chain is needed. The low address bits are the offset inside the slave, and the upper bits are the instance number. Write and read strobes go only to the addressed slave. The local address and the write data go to every slave. Each slave returns read data one cycle after its read strobe. The block keeps the instance number of a read for one cycle and uses it to route that slave's word back to the master.

Top module: `pow2_slave_mux`

## Requirements
- R1: Every slave address slot carries bits `[LA_W-1:0]` of `m_addr` unchanged in the same cycle. `LA_W` is the base-two logarithm of the rounded window, and is at least 1. For the default 5-word slave, `LA_W` = 3.
- R2: When `m_wr` is high and the instance index `m_addr[MA_W-1:LA_W]` is below `NOF_INST`, the bit of `s_wr` with that index is high in the same cycle. Every other bit of `s_wr` is low.
- R3: When `m_rd` is high and the instance index is below `NOF_INST`, the bit of `s_rd` with that index is high in the same cycle. Every other bit of `s_rd` is low.
- R4: When the instance index is `NOF_INST` or above, no bit of `s_wr` or `s_rd` is set, whatever the strobes on the master side.
- R5: The cycle after a read strobe reaches slave `k`, `m_rdata` equals bits `[32k+31:32k]` of `s_rdata`.
- R6: Reads in consecutive cycles to different instances each return the word of the slave that each one addressed.
- R7: A read whose instance index is out of range returns zero on `m_rdata` in the following cycle.
- R8: `m_rdata` is zero in every cycle that does not follow a cycle with a read strobe to some slave. This includes the cycles during and after reset.
- R9: Every slave write-data slot carries `m_wdata` unchanged in the same cycle.
- R10: Local offsets at or above the slave word count but inside the window are still routed to the addressed slave. For the 5-word default these are offsets 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| m_addr | input | MA_W | Master word address (instance index above the local offset) |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data, one cycle after the read |
| s_addr | output | NOF_INST*LA_W | Local offset, one slot per slave |
| s_wr | output | NOF_INST | Per-slave write strobe |
| s_rd | output | NOF_INST | Per-slave read strobe |
| s_wdata | output | NOF_INST*32 | Write data, one slot per slave |
| s_rdata | input | NOF_INST*32 | Read data from each slave |

## Verification
The assertions check four things on every cycle:
- At most one slave strobe is active at a time.
- Out-of-range addresses leave every slave strobe low.
- A read strobe to slave `k` brings that slave's word to the master one cycle later.
- The master read bus is zero after any cycle without a read strobe.

Only the bench's sweeps can show that the instance index and the offset are taken from the correct address bits. The same holds for the fill offsets inside a window reaching their slave, for write data and offsets being broadcast, and for back-to-back reads in a scrambled order returning each slave's own data.

// File: rtl/pow2mux_pkg.sv
package pow2mux_pkg;
  localparam int DATA_W = 32;

  typedef logic [DATA_W-1:0] word_t;

  // Number of bits needed to index n items, never less than one.
  function automatic int idx_bits(input int n);
    int b;
    b = $clog2(n);
    return (b < 1) ? 1 : b;
  endfunction
endpackage

// File: rtl/p2m_decode.sv
module p2m_decode #(
  parameter int NOF_INST = 3,
  parameter int LA_W     = 3,
  parameter int SEL_W    = 2
) (
  input  logic [LA_W+SEL_W-1:0] addr_i,
  output logic [SEL_W-1:0]      idx_o,
  output logic                  hit_o,
  output logic [LA_W-1:0]       local_o
);
  always_comb begin
    local_o = addr_i[LA_W-1:0];
    idx_o   = addr_i[LA_W+SEL_W-1:LA_W];
    hit_o   = (int'(idx_o) < NOF_INST);
  end
endmodule

// File: rtl/p2m_strobe.sv
module p2m_strobe #(
  parameter int NOF_INST = 3,
  parameter int SEL_W    = 2
) (
  input  logic [SEL_W-1:0]    idx_i,
  input  logic                hit_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [NOF_INST-1:0] wr_o,
  output logic [NOF_INST-1:0] rd_o
);
  for (genvar k = 0; k < NOF_INST; k++) begin : g_slot
    logic sel;
    assign sel     = hit_i && (idx_i == SEL_W'(k));
    assign wr_o[k] = sel && wr_i;
    assign rd_o[k] = sel && rd_i;
  end
endmodule

// File: rtl/p2m_rdret.sv
module p2m_rdret
  import pow2mux_pkg::*;
#(
  parameter int NOF_INST = 3,
  parameter int SEL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take_i,
  input  logic [SEL_W-1:0]           idx_i,
  input  logic [NOF_INST*DATA_W-1:0] s_rdata_i,
  output word_t                      m_rdata_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             vld_q, vld_d;

  // Next state: the select is loaded only when a read is taken.
  always_comb begin
    vld_d = take_i;
    sel_d = sel_q;
    if (take_i) sel_d = idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    m_rdata_o = '0;
    for (int k = 0; k < NOF_INST; k++) begin
      if (vld_q && (sel_q == SEL_W'(k))) m_rdata_o = s_rdata_i[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pow2_slave_mux.sv
module pow2_slave_mux
  import pow2mux_pkg::*;
#(
  parameter int NOF_INST  = 3,
  parameter int SLV_WORDS = 5,
  localparam int LA_W     = idx_bits(SLV_WORDS),
  localparam int SEL_W    = idx_bits(NOF_INST),
  localparam int MA_W     = LA_W + SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MA_W-1:0]            m_addr,
  input  logic                       m_wr,
  input  logic                       m_rd,
  input  logic [DATA_W-1:0]          m_wdata,
  output logic [DATA_W-1:0]          m_rdata,
  output logic [NOF_INST*LA_W-1:0]   s_addr,
  output logic [NOF_INST-1:0]        s_wr,
  output logic [NOF_INST-1:0]        s_rd,
  output logic [NOF_INST*DATA_W-1:0] s_wdata,
  input  logic [NOF_INST*DATA_W-1:0] s_rdata
);
  logic [SEL_W-1:0] idx;
  logic             hit;
  logic [LA_W-1:0]  loc;

  p2m_decode #(.NOF_INST(NOF_INST), .LA_W(LA_W), .SEL_W(SEL_W)) u_dec (
    .addr_i (m_addr),
    .idx_o  (idx),
    .hit_o  (hit),
    .local_o(loc)
  );

  p2m_strobe #(.NOF_INST(NOF_INST), .SEL_W(SEL_W)) u_stb (
    .idx_i(idx),
    .hit_i(hit),
    .wr_i (m_wr),
    .rd_i (m_rd),
    .wr_o (s_wr),
    .rd_o (s_rd)
  );

  p2m_rdret #(.NOF_INST(NOF_INST), .SEL_W(SEL_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (m_rd && hit),
    .idx_i    (idx),
    .s_rdata_i(s_rdata),
    .m_rdata_o(m_rdata)
  );

  for (genvar k = 0; k < NOF_INST; k++) begin : g_bcast
    assign s_addr[k*LA_W +: LA_W]      = loc;
    assign s_wdata[k*DATA_W +: DATA_W] = m_wdata;
  end
endmodule

// File: rtl/pow2_slave_mux_chk.sv
module pow2_slave_mux_chk
  import pow2mux_pkg::*;
#(
  parameter int NOF_INST  = 3,
  parameter int SLV_WORDS = 5,
  localparam int LA_W     = idx_bits(SLV_WORDS),
  localparam int SEL_W    = idx_bits(NOF_INST),
  localparam int MA_W     = LA_W + SEL_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [MA_W-1:0]            m_addr,
  input logic [NOF_INST-1:0]        s_wr,
  input logic [NOF_INST-1:0]        s_rd,
  input logic [NOF_INST*DATA_W-1:0] s_rdata,
  input logic [DATA_W-1:0]          m_rdata
);
  // R2
  p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_wr));
  // R3
  p_rd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_rd));
  // R4
  p_oor_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(m_addr[MA_W-1:LA_W]) >= NOF_INST) |-> (s_wr == '0 && s_rd == '0));
  // R7, R8
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd == '0) |=> (m_rdata == '0));
  // R5
  for (genvar k = 0; k < NOF_INST; k++) begin : g_ret
    p_rdata_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_rd[k] |=> (m_rdata == s_rdata[k*DATA_W +: DATA_W]));
  end
endmodule

bind pow2_slave_mux pow2_slave_mux_chk #(.NOF_INST(NOF_INST), .SLV_WORDS(SLV_WORDS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .m_addr (m_addr),
  .s_wr   (s_wr),
  .s_rd   (s_rd),
  .s_rdata(s_rdata),
  .m_rdata(m_rdata)
);

// File: tb/pow2_slave_mux_tb.sv
`timescale 1ns/1ps
module pow2_slave_mux_tb;
  localparam int N    = 3;
  localparam int SW   = 5;
  localparam int LA   = 3;
  localparam int SEL  = 2;
  localparam int MA   = LA + SEL;
  localparam int SPAN = 1 << MA;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [MA-1:0]   m_addr;
  logic            m_wr, m_rd;
  logic [31:0]     m_wdata, m_rdata;
  logic [N*LA-1:0] s_addr;
  logic [N-1:0]    s_wr, s_rd;
  logic [N*32-1:0] s_wdata, s_rdata;
  logic [31:0]     slv_q [N];

  int    n_vec = 0;
  int    n_bad = 0;
  bit    pend = 1'b0;
  logic [31:0] pend_exp;
  string pend_tag;

  always #2.5 clk = ~clk;

  pow2_slave_mux #(.NOF_INST(N), .SLV_WORDS(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .s_addr(s_addr), .s_wr(s_wr),
    .s_rd(s_rd), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // Slave models: one-cycle read latency; a slave that was not read shows a non-zero filler word.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (s_rd[i]) slv_q[i] <= {8'hA5, 8'(i), 13'h0, s_addr[i*LA +: LA]};
      else         slv_q[i] <= 32'hBAD0_0000 | 32'(i);
    end
  end
  always_comb begin
    for (int i = 0; i < N; i++) s_rdata[i*32 +: 32] = slv_q[i];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input bit rd, input bit wr, input string rtag);
    int          idx;
    int          loc;
    logic [31:0] wd;
    logic [N-1:0] exp_stb;
    @(negedge clk);
    if (pend) chk(pend_tag, m_rdata, pend_exp);
    else      chk("R8", m_rdata, 32'h0);
    idx = a >> LA;
    loc = a & ((1 << LA) - 1);
    wd = 32'h1234_0000 ^ (32'(a) * 32'h0101_0037);
    m_addr = MA'(a); m_rd = rd; m_wr = wr; m_wdata = wd;
    #1;
    exp_stb = (idx < N) ? N'(1 << idx) : '0;
    chk((idx < N) ? "R3" : "R4", 32'(s_rd), rd ? 32'(exp_stb) : 32'h0);
    chk((idx < N) ? "R2" : "R4", 32'(s_wr), wr ? 32'(exp_stb) : 32'h0);
    for (int i = 0; i < N; i++) begin
      chk((loc >= SW) ? "R10" : "R1", 32'(s_addr[i*LA +: LA]), 32'(loc));
      chk("R9", s_wdata[i*32 +: 32], wd);
    end
    pend = rd;
    if (rd) begin
      pend_exp = (idx < N) ? {8'hA5, 8'(idx), 13'h0, 3'(loc)} : 32'h0;
      pend_tag = (idx < N) ? rtag : "R7";
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; m_addr = '0; m_wr = 1'b0; m_rd = 1'b0; m_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R8", m_rdata, 32'h0);
    chk("R3", 32'(s_rd), 32'h0);
    rst_n = 1'b1;
    // Sequential back-to-back read sweep over the whole address space.
    for (int a = 0; a < SPAN; a++) apply(a, 1'b1, 1'b0, "R5");
    apply(0, 1'b0, 1'b0, "R8");
    // Write sweep: strobes only; read bus must stay zero (R8).
    for (int a = 0; a < SPAN; a++) apply(a, 1'b0, 1'b1, "R2");
    // Scrambled order, so consecutive reads hit different instances (R6).
    for (int a = 0; a < SPAN; a++) apply((a * 13 + 7) % SPAN, 1'b1, 1'b0, "R6");
    // Alternate first and last slave, then out of range, then idle.
    for (int a = 0; a < 8; a++) apply((a % 2 == 0) ? a : (2 << LA) + a, 1'b1, 1'b0, "R6");
    apply(SPAN - 1, 1'b1, 1'b0, "R7");
    apply(1, 1'b0, 1'b0, "R8");
    apply(1, 1'b0, 1'b0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule